// File: doc/BRIEF.md
# Display Controller Init Script Player

This block brings up a display controller over a parallel write-only bus of the 8080 kind. It steps through a byte-packed setup script held in a small built-in ROM. Each record opens with a header byte. The header's two top bits say whether a command byte and a trailing wait byte are present. Its low six bits count the parameter bytes. The block turns each command and parameter into one bus write, which uses chip-select, register-select and a write strobe. A wait byte becomes a pause counted in ticks of a divided clock.

The first run after the block leaves reset is special. The controller's reset pin is first pulled low for a set number of ticks and then released, and the block waits the same number of ticks again before it selects the chip. A `start` pulse launches a run. `busy` stays high until the run finishes, and `done` pulses for one clock when the end of the script is reached.

Top module: `initseq_player`

## Requirements
- R1: A header byte is decoded as follows: bit 6 set means a command byte follows, bit 7 set means a wait byte follows, and bits 5:0 give the number of parameter bytes that follow.
- R2: Within a record the bytes come in this order: header, command (when flagged), parameters, then the wait byte (when flagged). The pause applies only after the last parameter write.
- R3: A command byte is written with `lcd_rs_o` low. A parameter byte is written with `lcd_rs_o` high.
- R4: Each write drives the byte onto `lcd_data_o` and pulls `lcd_wr_n_o` low for at least WR_LO clocks. The byte stays stable while the strobe is low and on its rising edge, and the strobe stays high for at least WR_HI clocks before the next write.
- R5: `lcd_cs_n_o` goes low once per run and stays low until the script is exhausted. It then rises, and `done_o` pulses high for exactly one clock.
- R6: A wait byte of value N holds off the next bus write by at least N*TICK_CLKS clocks. A value of 0 adds no pause.
- R7: On the first run after reset, `lcd_rst_n_o` is held low for RST_TICKS ticks while chip-select and both strobes stay high. The block then waits another RST_TICKS ticks before chip-select falls. Later runs skip this pulse.
- R8: A header with the command flag set and a zero count produces a single command write with no parameters.
- R9: When the script length is reached in the middle of a record, the run ends at once and no further writes occur.
- R10: A `start_i` pulse that arrives while `busy_o` is high has no effect: it adds no writes, causes no restart and produces no extra `done_o`.
- R11: Out of reset, chip-select, both strobes and the reset pin are high, and `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Launch a script run (ignored while busy) |
| busy_o | output | 1 | Run or reset pulse in progress |
| done_o | output | 1 | One-clock pulse at end of run |
| lcd_cs_n_o | output | 1 | Bus chip-select, active low |
| lcd_rs_o | output | 1 | Register-select: 0 command, 1 parameter |
| lcd_wr_n_o | output | 1 | Write strobe, active low |
| lcd_rd_n_o | output | 1 | Read strobe, held high |
| lcd_rst_n_o | output | 1 | Controller hardware reset, active low |
| lcd_data_o | output | 8 | Bus data byte |

## Verification
The bench builds the block with TICK_CLKS=4, RST_TICKS=100 and WR_LO=WR_HI=2, using the default 21-byte example script. The short tick makes the 100-tick reset pulse and the wait bytes of 3, 2 and 0 ticks last only tens to hundreds of clocks, so their gaps can be measured against exact bounds in one short run. The example script ends part-way through a record and contains a bare command, a record with only a wait byte and a record with only a parameter. This lets the truncation, ordering and register-select cases be reached without changing the script.

// File: rtl/initseq_pkg.sv
package initseq_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_RLOW, S_RWAIT, S_HDR, S_CMD, S_PAR, S_XFER, S_DLY, S_WAIT, S_END
  } seq_state_e;

  localparam int HDR_DLY_BIT = 7;
  localparam int HDR_CMD_BIT = 6;
  localparam int HDR_CNT_W   = 6;

  localparam int EXAMPLE_LEN = 21;

  // Example bring-up script; addresses past the end read as zero.
  function automatic logic [7:0] script_byte(input int idx);
    case (idx)
      0:  script_byte = 8'h40;  // bare command
      1:  script_byte = 8'h01;
      2:  script_byte = 8'hC2;  // command, two params, wait
      3:  script_byte = 8'hB0;
      4:  script_byte = 8'h12;
      5:  script_byte = 8'h34;
      6:  script_byte = 8'h03;
      7:  script_byte = 8'h01;  // lone parameter
      8:  script_byte = 8'h5A;
      9:  script_byte = 8'h80;  // wait only
      10: script_byte = 8'h02;
      11: script_byte = 8'h43;  // command, three params
      12: script_byte = 8'h2A;
      13: script_byte = 8'h00;
      14: script_byte = 8'h01;
      15: script_byte = 8'hEF;
      16: script_byte = 8'hC0;  // command, zero wait
      17: script_byte = 8'h29;
      18: script_byte = 8'h00;
      19: script_byte = 8'h41;  // command, one param (truncated)
      20: script_byte = 8'h36;
      default: script_byte = 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/initseq_timer.sv
module initseq_timer #(
  parameter int TICK_CLKS = 1000,
  parameter int CNT_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] ticks_i,
  output logic             zero_o
);
  localparam int PW = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_CLKS - 1);

  logic [CNT_W-1:0] tick_q, tick_d;
  logic [PW-1:0]    pre_q, pre_d;

  always_comb begin
    tick_d = tick_q;
    pre_d  = pre_q;
    if (load_i) begin
      tick_d = ticks_i;
      pre_d  = '0;
    end else if (tick_q != '0) begin
      if (pre_q == PRE_LAST) begin
        pre_d  = '0;
        tick_d = tick_q - 1'b1;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tick_q <= '0;
      pre_q  <= '0;
    end else begin
      tick_q <= tick_d;
      pre_q  <= pre_d;
    end
  end

  assign zero_o = (tick_q == '0);

  // R6: a running wait only ever counts down
  assert_tick_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && tick_q != '0) |=> (tick_q <= $past(tick_q)));

endmodule

// File: rtl/initseq_strobe.sv
module initseq_strobe #(
  parameter int WR_LO = 2,
  parameter int WR_HI = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go_i,
  input  logic       rs_i,
  input  logic [7:0] data_i,
  output logic       done_o,
  output logic       wr_n_o,
  output logic       rs_o,
  output logic [7:0] data_o
);
  localparam int MAXP = (WR_LO > WR_HI) ? WR_LO : WR_HI;
  localparam int CW   = $clog2(MAXP + 1);
  localparam logic [CW-1:0] LO_LAST = CW'(WR_LO - 1);
  localparam logic [CW-1:0] HI_LAST = CW'(WR_HI - 1);

  typedef enum logic [1:0] {P_IDLE, P_LO, P_HI} ph_e;

  ph_e         ph_q, ph_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic        rs_q, rs_d;
  logic [7:0]  dat_q, dat_d;

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    rs_d  = rs_q;
    dat_d = dat_q;
    case (ph_q)
      P_IDLE: if (go_i) begin
        ph_d  = P_LO;
        cnt_d = LO_LAST;
        rs_d  = rs_i;
        dat_d = data_i;
      end
      P_LO: if (cnt_q == '0) begin
        ph_d  = P_HI;
        cnt_d = HI_LAST;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      P_HI: if (cnt_q == '0) ph_d = P_IDLE;
            else cnt_d = cnt_q - 1'b1;
      default: ph_d = P_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= P_IDLE;
      cnt_q <= '0;
      rs_q  <= 1'b1;
      dat_q <= '0;
    end else begin
      ph_q  <= ph_d;
      cnt_q <= cnt_d;
      rs_q  <= rs_d;
      dat_q <= dat_d;
    end
  end

  assign done_o = (ph_q == P_HI) && (cnt_q == '0);
  assign wr_n_o = (ph_q != P_LO);
  assign rs_o   = rs_q;
  assign data_o = dat_q;

  // R4: bus byte and select hold while strobe is low and at its rising edge
  assert_data_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(wr_n_o)) |-> ($stable(data_o) && $stable(rs_o)));

endmodule

// File: rtl/initseq_seq.sv
module initseq_seq
  import initseq_pkg::*;
#(
  parameter int SCRIPT_LEN = EXAMPLE_LEN,
  parameter int RST_TICKS  = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       tmr_zero_i,
  output logic       tmr_load_o,
  output logic [7:0] tmr_val_o,
  input  logic       wr_done_i,
  output logic       wr_go_o,
  output logic       wr_rs_o,
  output logic [7:0] wr_data_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       cs_n_o,
  output logic       lcd_rst_n_o
);
  localparam int AW = $clog2(SCRIPT_LEN + 1);
  localparam logic [AW-1:0] END_ADDR = AW'(SCRIPT_LEN);
  localparam logic [7:0]    RST_VAL  = 8'(RST_TICKS);

  seq_state_e            st_q, st_d;
  logic [AW-1:0]         addr_q, addr_d;
  logic [HDR_CNT_W-1:0]  cnt_q, cnt_d;
  logic                  dly_q, dly_d;
  logic                  pwr_q, pwr_d;
  logic [7:0]            cur;
  logic                  at_end;

  assign cur    = script_byte(int'(addr_q));
  assign at_end = (addr_q == END_ADDR);

  always_comb begin
    st_d       = st_q;
    addr_d     = addr_q;
    cnt_d      = cnt_q;
    dly_d      = dly_q;
    pwr_d      = pwr_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = RST_VAL;
    wr_go_o    = 1'b0;
    wr_rs_o    = 1'b1;
    wr_data_o  = cur;
    case (st_q)
      S_IDLE: if (start_i) begin
        addr_d = '0;
        if (pwr_q) st_d = S_HDR;
        else begin
          tmr_load_o = 1'b1;
          st_d       = S_RLOW;
        end
      end
      S_RLOW: if (tmr_zero_i) begin
        tmr_load_o = 1'b1;
        st_d       = S_RWAIT;
      end
      S_RWAIT: if (tmr_zero_i) begin
        pwr_d = 1'b1;
        st_d  = S_HDR;
      end
      S_HDR: begin
        if (at_end) st_d = S_END;
        else begin
          addr_d = addr_q + 1'b1;
          cnt_d  = cur[HDR_CNT_W-1:0];
          dly_d  = cur[HDR_DLY_BIT];
          if (cur[HDR_CMD_BIT])               st_d = S_CMD;
          else if (cur[HDR_CNT_W-1:0] != '0)  st_d = S_PAR;
          else if (cur[HDR_DLY_BIT])          st_d = S_DLY;
          else                                st_d = S_HDR;
        end
      end
      S_CMD, S_PAR: begin
        if (at_end) st_d = S_END;
        else begin
          wr_go_o = 1'b1;
          wr_rs_o = (st_q == S_PAR);
          addr_d  = addr_q + 1'b1;
          if (st_q == S_PAR) cnt_d = cnt_q - 1'b1;
          st_d = S_XFER;
        end
      end
      S_XFER: if (wr_done_i) begin
        if (cnt_q != '0) st_d = S_PAR;
        else if (dly_q)  st_d = S_DLY;
        else             st_d = S_HDR;
      end
      S_DLY: begin
        if (at_end) st_d = S_END;
        else begin
          tmr_load_o = 1'b1;
          tmr_val_o  = cur;
          addr_d     = addr_q + 1'b1;
          st_d       = S_WAIT;
        end
      end
      S_WAIT: if (tmr_zero_i) st_d = S_HDR;
      S_END:  st_d = S_IDLE;
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      addr_q <= '0;
      cnt_q  <= '0;
      dly_q  <= 1'b0;
      pwr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
      dly_q  <= dly_d;
      pwr_q  <= pwr_d;
    end
  end

  assign busy_o      = (st_q != S_IDLE);
  assign done_o      = (st_q == S_END);
  assign lcd_rst_n_o = (st_q != S_RLOW);
  assign cs_n_o      = (st_q == S_IDLE) || (st_q == S_RLOW) ||
                       (st_q == S_RWAIT) || (st_q == S_END);

  // R5: completion is a single-cycle pulse
  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  // R10: a start seen mid-run never sends the script pointer back to zero
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && st_q == S_XFER && !wr_done_i) |=> (addr_q == $past(addr_q)));

endmodule

// File: rtl/initseq_player.sv
module initseq_player #(
  parameter int SCRIPT_LEN = initseq_pkg::EXAMPLE_LEN,
  parameter int TICK_CLKS  = 1000,
  parameter int RST_TICKS  = 100,
  parameter int WR_LO      = 2,
  parameter int WR_HI      = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       lcd_cs_n_o,
  output logic       lcd_rs_o,
  output logic       lcd_wr_n_o,
  output logic       lcd_rd_n_o,
  output logic       lcd_rst_n_o,
  output logic [7:0] lcd_data_o
);
  logic       tmr_load, tmr_zero;
  logic [7:0] tmr_val;
  logic       wr_go, wr_rs, wr_done;
  logic [7:0] wr_data;

  initseq_seq #(
    .SCRIPT_LEN(SCRIPT_LEN),
    .RST_TICKS (RST_TICKS)
  ) seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .tmr_zero_i (tmr_zero),
    .tmr_load_o (tmr_load),
    .tmr_val_o  (tmr_val),
    .wr_done_i  (wr_done),
    .wr_go_o    (wr_go),
    .wr_rs_o    (wr_rs),
    .wr_data_o  (wr_data),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .cs_n_o     (lcd_cs_n_o),
    .lcd_rst_n_o(lcd_rst_n_o)
  );

  initseq_timer #(
    .TICK_CLKS(TICK_CLKS),
    .CNT_W    (8)
  ) tmr_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_i (tmr_load),
    .ticks_i(tmr_val),
    .zero_o (tmr_zero)
  );

  initseq_strobe #(
    .WR_LO(WR_LO),
    .WR_HI(WR_HI)
  ) stb_i (
    .clk   (clk),
    .rst_n (rst_n),
    .go_i  (wr_go),
    .rs_i  (wr_rs),
    .data_i(wr_data),
    .done_o(wr_done),
    .wr_n_o(lcd_wr_n_o),
    .rs_o  (lcd_rs_o),
    .data_o(lcd_data_o)
  );

  assign lcd_rd_n_o = 1'b1;

  // R5: every write strobe falls inside a chip-select window
  assert_wr_inside_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_wr_n_o |-> !lcd_cs_n_o);

  // R7: while the controller is held in reset the bus is idle
  assert_rst_bus_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_rst_n_o |-> (lcd_cs_n_o && lcd_wr_n_o && lcd_rd_n_o));

endmodule

// File: tb/initseq_player_tb.sv
`timescale 1ns/1ps
module initseq_player_tb_top;
  localparam int T     = 4;
  localparam int RSTT  = 100;
  localparam int WLO   = 2;
  localparam int WHI   = 2;
  localparam int NEXP  = 11;
  localparam int GAPX  = 10;

  // {rs, data, wait ticks before this write}
  localparam logic [16:0] VEC [NEXP] = '{
    {1'b0, 8'h01, 8'd0}, {1'b0, 8'hB0, 8'd0}, {1'b1, 8'h12, 8'd0},
    {1'b1, 8'h34, 8'd0}, {1'b1, 8'h5A, 8'd3}, {1'b0, 8'h2A, 8'd2},
    {1'b1, 8'h00, 8'd0}, {1'b1, 8'h01, 8'd0}, {1'b1, 8'hEF, 8'd0},
    {1'b0, 8'h29, 8'd0}, {1'b0, 8'h36, 8'd0}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, done, cs_n, rs, wr_n, rd_n, lrst_n;
  logic [7:0] data;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  initseq_player #(
    .TICK_CLKS(T), .RST_TICKS(RSTT), .WR_LO(WLO), .WR_HI(WHI)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
    .lcd_cs_n_o(cs_n), .lcd_rs_o(rs), .lcd_wr_n_o(wr_n), .lcd_rd_n_o(rd_n),
    .lcd_rst_n_o(lrst_n), .lcd_data_o(data)
  );

  // bus monitor, samples on the falling clock edge
  int cyc = 0, nw = 0, lo_run = 0, rst_low = 0, cs_rises = 0, dones = 0;
  int rst_rise_t = 0, cs_fall_t = 0, dwide = 0;
  logic p_wr = 1'b1, p_cs = 1'b1, p_rst = 1'b1, p_done = 1'b0;
  logic       cap_rs [64];
  logic [7:0] cap_d  [64];
  int fall_t [64];
  int rise_t [64];
  int lo_len [64];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (p_wr && !wr_n) begin
      fall_t[nw] <= cyc;
      lo_run <= 1;
    end else if (!wr_n) lo_run <= lo_run + 1;
    if (!p_wr && wr_n && nw < 64) begin
      cap_rs[nw] <= rs;
      cap_d[nw]  <= data;
      lo_len[nw] <= lo_run;
      rise_t[nw] <= cyc;
      nw <= nw + 1;
    end
    if (!lrst_n) rst_low <= rst_low + 1;
    if (!p_rst && lrst_n) rst_rise_t <= cyc;
    if (p_cs && !cs_n) cs_fall_t <= cyc;
    if (!p_cs && cs_n) cs_rises <= cs_rises + 1;
    if (done) dones <= dones + 1;
    if (done && p_done) dwide <= dwide + 1;
    p_wr <= wr_n; p_cs <= cs_n; p_rst <= lrst_n; p_done <= done;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic wait_done(input int limit);
    int n = 0;
    while (!done && n < limit) begin @(negedge clk); n++; end
    chk(done, "R5", "done seen before timeout", int'(done), 1);
    @(negedge clk);
  endtask

  task automatic check_writes(input int base, input string tag);
    chk(nw - base == NEXP, "R9", {tag, " write count"}, nw - base, NEXP);
    for (int k = 0; k < NEXP; k++) begin
      logic       ers = VEC[k][16];
      logic [7:0] ed  = VEC[k][15:8];
      int         ew  = int'(VEC[k][7:0]) * T;
      chk(cap_rs[base+k] == ers, "R3", {tag, " rs level"}, int'(cap_rs[base+k]), int'(ers));
      chk(cap_d[base+k] == ed, "R1", {tag, " data byte"}, int'(cap_d[base+k]), int'(ed));
      chk(lo_len[base+k] >= WLO, "R4", {tag, " strobe low width"}, lo_len[base+k], WLO);
      if (k > 0) begin
        int g = fall_t[base+k] - rise_t[base+k-1];
        chk(g >= ew && g <= ew + GAPX, "R6", {tag, " gap before write"}, g, ew);
        chk(g >= WHI, "R4", {tag, " strobe high width"}, g, WHI);
      end
    end
  endtask

  int base, rl0, cr0, dn0;

  initial begin
    repeat (3) @(negedge clk);
    // R11: quiet outputs held in reset and just after
    chk(cs_n && wr_n && rd_n && lrst_n, "R11", "bus idle in reset",
        int'({cs_n, wr_n, rd_n, lrst_n}), 15);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done, "R11", "not busy after reset", int'({busy, done}), 0);

    // first run: reset pulse then script (R7, R2, R8)
    base = nw; cr0 = cs_rises; dn0 = dones;
    pulse_start();
    chk(busy, "R7", "busy during reset pulse", int'(busy), 1);
    wait_done(5000);
    chk(rst_low >= RSTT*T && rst_low <= RSTT*T + 2, "R7", "reset low cycles",
        rst_low, RSTT*T);
    chk(cs_fall_t - rst_rise_t >= RSTT*T, "R7", "wait after reset release",
        cs_fall_t - rst_rise_t, RSTT*T);
    check_writes(base, "run1");
    chk(cs_rises - cr0 == 1, "R5", "single cs window run1", cs_rises - cr0, 1);
    chk(dones - dn0 == 1 && dwide == 0, "R5", "done pulse run1", dones - dn0, 1);
    chk(cs_n && !busy, "R5", "cs released at end", int'({cs_n, busy}), 2);
    // R8: first record is a bare command followed directly by the next command
    chk(cap_rs[base] == 1'b0 && cap_rs[base+1] == 1'b0, "R8", "bare command",
        int'({cap_rs[base], cap_rs[base+1]}), 0);

    // second run: no reset pulse, extra starts while busy ignored (R10)
    base = nw; rl0 = rst_low; cr0 = cs_rises; dn0 = dones;
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    repeat (20) @(negedge clk);
    pulse_start();
    wait_done(5000);
    repeat (20) @(negedge clk);
    chk(rst_low == rl0, "R7", "no reset pulse on later run", rst_low - rl0, 0);
    check_writes(base, "run2");
    chk(dones - dn0 == 1, "R10", "one done despite extra starts", dones - dn0, 1);
    chk(cs_rises - cr0 == 1, "R10", "no restart window", cs_rises - cr0, 1);
    chk(!busy && nw - base == NEXP, "R10", "idle with no extra writes", nw - base, NEXP);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog expired: actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule